// File: doc/BRIEF.md
# Addressed Three-Wire Configuration Command Decoder

This block takes configuration traffic from a host over a three-wire serial port (a data line, a serial clock and an active-low select) and turns it into a live configuration table for a bank of half-channels. All three wires are brought into the core clock domain through synchronizers. The data line is sampled on each rising serial-clock edge while select is low, and the samples are packed into bytes. Each low period of the select line is one command sequence. The first byte of a sequence is a header that names the target chip through a two-bit strap and selects one of five command kinds.

Three of the kinds carry payloads. A channel-setup command carries seven-byte slot and mode records, one for each half-channel, and ends with a footer byte. A channel-control command carries a starting channel number and then two bytes for each channel. A clock-setup command carries a clock-divider value and three multiplier and divider fields, which the block only stores. The other two kinds, power-up and power-down, are single bytes that produce one-cycle strobes.

A setup command changes the table only when its footer arrives. Until then the incoming records are kept in a staging copy, so a sequence that is cut short leaves the table as it was. Control pairs are applied one at a time as each pair completes. The table contents, the stored clock fields and the strobes are all plain outputs, with no handshake. The serial port has no back-pressure: the host paces the bytes with the serial clock, and the block accepts every byte it receives.

Top module: `tw_cfg_decoder`

## Requirements
- R1: After reset, half-channels 0 to NUM_CH/2-1 hold decoder defaults: input and output on Y, resource allocated, decode set, rate code 10 (32k), input slot 16k..16k+3 and output slot 16k..16k+7. The remaining half-channels j=k-NUM_CH/2 hold encoder defaults: input and output on X, allocated, decode clear, rate 10, input slot 16j..16j+7 and output slot 16j..16j+3. Every channel starts with reset=1, bypass=0, A-law=0 (mu-law) and idle=0. The clock fields start at divider 7, N 6, M 1 and P 3.
- R2: Each data bit is sampled on a rising serial-clock edge while select is low, and the first bit of a byte is its LSB. Serial-clock edges while select is high are ignored. An incomplete byte at the rise of select is dropped.
- R3: Header bits [1:0] must equal the chip_id strap. When they do not, every byte of that sequence is ignored.
- R4: Header 0001_00ii gives exactly one pwr_up pulse of one cycle, and header 0000_10ii gives exactly one pwr_dn pulse of one cycle. Any further bytes in the same sequence are ignored.
- R5: Header 0000_00ii opens a setup. It is followed by seven-byte records that apply to channels 0, 1, 2 and so on, in order, and a footer byte 0xFF at a record boundary. In each record, byte 0 holds the input port in bit 7 (1=Y), the output port in bit 6 and allocate in bit 4. Byte 1 holds decode in bit 6 and the rate code in bits [2:1]. Byte 2 is unused. Bytes 3 to 6 are the input begin, input end, output begin and output end slots. The footer applies all the records together, and channels without a record keep their values.
- R6: A setup sequence that ends (select rises) before its footer changes no channel, including channels whose records were complete.
- R7: A setup carrying more than NUM_CH records is discarded whole, even if a footer follows.
- R8: Header 0011_00ii opens a control command. The next byte is the start channel. Then come byte pairs for consecutive channels: in the first byte, bit 4 is reset, bit 2 is bypass and bit 0 is A-law; in the second byte, bit 0 is idle. Each pair takes effect when its second byte arrives.
- R9: A control pair missing its second byte is not applied. Pairs aimed at channel numbers of NUM_CH or above are ignored.
- R10: A header with bit 7 set opens a clock command. Header bits [6:3] are the divider. Byte 2 bits [7:1] are N. M is {byte 2 bit 0, byte 3 bits [7:3]} and P is byte 3 bits [2:0]. The fields update only once the third byte arrives.
- R11: A matching header of any other form is ignored together with the rest of its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_id | input | 2 | Strapped chip address |
| ser_clk | input | 1 | Serial clock |
| ser_csn | input | 1 | Serial select, active low |
| ser_dat | input | 1 | Serial data in |
| ch_in_y | output | NUM_CH | Input port per channel (1=Y) |
| ch_out_y | output | NUM_CH | Output port per channel (1=Y) |
| ch_alloc | output | NUM_CH | Resource allocated per channel |
| ch_decode | output | NUM_CH | Decode (1) or encode (0) per channel |
| ch_rate | output | 2*NUM_CH | Rate code per channel |
| ch_in_begin | output | 8*NUM_CH | Input begin slot per channel |
| ch_in_end | output | 8*NUM_CH | Input end slot per channel |
| ch_out_begin | output | 8*NUM_CH | Output begin slot per channel |
| ch_out_end | output | 8*NUM_CH | Output end slot per channel |
| ch_reset | output | NUM_CH | Algorithm reset per channel |
| ch_bypass | output | NUM_CH | Bypass per channel |
| ch_law_a | output | NUM_CH | A-law select per channel |
| ch_idle | output | NUM_CH | Idle per channel |
| clk_div | output | 4 | Stored clock divider |
| pll_n | output | 7 | Stored multiplier N |
| pll_m | output | 6 | Stored divider M |
| pll_p | output | 3 | Stored divider code P |
| pwr_up | output | 1 | One-cycle power-up strobe |
| pwr_dn | output | 1 | One-cycle power-down strobe |

## Verification
Some properties are checked on every cycle by the assertions. The live setup table changes only in a commit cycle, a control entry changes only on a control write, and the clock fields change only on a clock write. Write indices always stay within the bank. The two power strobes never coincide and never last longer than one cycle, and no two bytes are reported in consecutive cycles. Other behaviour can only be shown by the bench scenarios: LSB-first assembly, chip-ID filtering, the field layout of records and pairs, channel ordering, and the cases where an interrupted, overlong or unknown sequence changes nothing. Each scenario is checked by comparing the full table against a model.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] RATE_16K = 2'b00;
  localparam logic [1:0] RATE_24K = 2'b01;
  localparam logic [1:0] RATE_32K = 2'b10;
  localparam logic [1:0] RATE_40K = 2'b11;

  typedef struct packed {
    logic              in_y;
    logic              out_y;
    logic              alloc;
    logic              dec;
    logic [1:0]        rate;
    logic [BYTE_W-1:0] in_b;
    logic [BYTE_W-1:0] in_e;
    logic [BYTE_W-1:0] out_b;
    logic [BYTE_W-1:0] out_e;
  } setup_t;

  typedef struct packed {
    logic rst;
    logic byp;
    logic law_a;
    logic idle;
  } ctl_t;

  typedef struct packed {
    logic [3:0] fdiv;
    logic [6:0] n;
    logic [5:0] m;
    logic [2:0] p;
  } pll_t;

  typedef enum logic [2:0] {
    S_HDR, S_SETUP, S_CSTART, S_CHI, S_CLO, S_PLL2, S_PLL3, S_SKIP
  } pst_t;

  localparam ctl_t CTL_RST = '{rst: 1'b1, byp: 1'b0, law_a: 1'b0, idle: 1'b0};
  localparam pll_t PLL_RST = '{fdiv: 4'd7, n: 7'd6, m: 6'd1, p: 3'd3};

  function automatic setup_t setup_default(input int ch, input int nch);
    setup_t s;
    int     half;
    int     j;
    half = nch / 2;
    s.alloc = 1'b1;
    s.rate  = RATE_32K;
    if (ch < half) begin
      s.in_y  = 1'b1;
      s.out_y = 1'b1;
      s.dec   = 1'b1;
      s.in_b  = BYTE_W'(16 * ch);
      s.in_e  = BYTE_W'(16 * ch + 3);
      s.out_b = BYTE_W'(16 * ch);
      s.out_e = BYTE_W'(16 * ch + 7);
    end else begin
      j = ch - half;
      s.in_y  = 1'b0;
      s.out_y = 1'b0;
      s.dec   = 1'b0;
      s.in_b  = BYTE_W'(16 * j);
      s.in_e  = BYTE_W'(16 * j + 7);
      s.out_b = BYTE_W'(16 * j);
      s.out_e = BYTE_W'(16 * j + 3);
    end
    return s;
  endfunction

endpackage

// File: rtl/tw_bit_rx.sv
module tw_bit_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_csn,
  input  logic       ser_dat,
  output logic       byte_vld,
  output logic [7:0] byte_d,
  output logic       seq_start,
  output logic       seq_end
);

  logic [SYNC_STAGES-1:0] sclk_q, csn_q, dat_q;
  logic                   sclk_d, csn_d;
  logic [2:0]             bitcnt;
  logic [6:0]             shreg;
  logic                   sclk_s, csn_s, dat_s, rise;

  assign sclk_s = sclk_q[SYNC_STAGES-1];
  assign csn_s  = csn_q[SYNC_STAGES-1];
  assign dat_s  = dat_q[SYNC_STAGES-1];
  assign rise   = sclk_s & ~sclk_d & ~csn_s;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_q <= '0;
          csn_q  <= '1;
          dat_q  <= '0;
        end else begin
          sclk_q <= {sclk_q[SYNC_STAGES-2:0], ser_clk};
          csn_q  <= {csn_q[SYNC_STAGES-2:0], ser_csn};
          dat_q  <= {dat_q[SYNC_STAGES-2:0], ser_dat};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_q <= '0;
          csn_q  <= '1;
          dat_q  <= '0;
        end else begin
          sclk_q <= ser_clk;
          csn_q  <= ser_csn;
          dat_q  <= ser_dat;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      csn_d     <= 1'b1;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_d    <= '0;
      seq_start <= 1'b0;
      seq_end   <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      csn_d     <= csn_s;
      byte_vld  <= 1'b0;
      seq_start <= csn_d & ~csn_s;
      seq_end   <= ~csn_d & csn_s;
      if (csn_s) begin
        bitcnt <= '0;
      end else if (rise) begin
        shreg  <= {dat_s, shreg[6:1]};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_d   <= {dat_s, shreg};
        end
      end
    end
  end

  AST_BYTE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R2
  AST_NO_BYTE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |-> !byte_vld); // R2

endmodule

// File: rtl/tw_cmd_parser.sv
module tw_cmd_parser
  import tw_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = CH_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      chip_id,
  input  logic            byte_vld,
  input  logic [7:0]      byte_d,
  input  logic            seq_start,
  input  logic            seq_end,
  output logic            pwr_up,
  output logic            pwr_dn,
  output logic            stg_load,
  output logic            stg_commit,
  output logic            rec_wr,
  output logic [CH_W-1:0] rec_idx,
  output setup_t          rec,
  output logic            ctl_wr,
  output logic [CH_W-1:0] ctl_ch,
  output ctl_t            ctl_val,
  output logic            pll_wr,
  output pll_t            pll_val
);

  pst_t             st;
  logic [2:0]       bcnt;
  logic [CNT_W-1:0] rcnt;
  logic [8:0]       ptr;
  logic             hi_rst, hi_byp, hi_law;
  logic [3:0]       f_q;
  logic [6:0]       n_q;
  logic             m5_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_HDR;
      bcnt       <= '0;
      rcnt       <= '0;
      ptr        <= '0;
      hi_rst     <= 1'b0;
      hi_byp     <= 1'b0;
      hi_law     <= 1'b0;
      f_q        <= '0;
      n_q        <= '0;
      m5_q       <= 1'b0;
      rec        <= '0;
      rec_idx    <= '0;
      ctl_ch     <= '0;
      ctl_val    <= '0;
      pll_val    <= '0;
      pwr_up     <= 1'b0;
      pwr_dn     <= 1'b0;
      stg_load   <= 1'b0;
      stg_commit <= 1'b0;
      rec_wr     <= 1'b0;
      ctl_wr     <= 1'b0;
      pll_wr     <= 1'b0;
    end else begin
      pwr_up     <= 1'b0;
      pwr_dn     <= 1'b0;
      stg_load   <= 1'b0;
      stg_commit <= 1'b0;
      rec_wr     <= 1'b0;
      ctl_wr     <= 1'b0;
      pll_wr     <= 1'b0;
      if (seq_start || seq_end) begin
        st <= S_HDR;
      end else if (byte_vld) begin
        case (st)
          S_HDR: begin
            if (byte_d[1:0] != chip_id) begin
              st <= S_SKIP;
            end else if (byte_d[7]) begin
              f_q <= byte_d[6:3];
              st  <= S_PLL2;
            end else if (byte_d[7:2] == 6'b001100) begin
              st <= S_CSTART;
            end else if (byte_d[7:2] == 6'b000100) begin
              pwr_up <= 1'b1;
              st     <= S_SKIP;
            end else if (byte_d[7:2] == 6'b000010) begin
              pwr_dn <= 1'b1;
              st     <= S_SKIP;
            end else if (byte_d[7:2] == 6'b000000) begin
              stg_load <= 1'b1;
              bcnt     <= '0;
              rcnt     <= '0;
              st       <= S_SETUP;
            end else begin
              st <= S_SKIP;
            end
          end
          S_SETUP: begin
            if (bcnt == 3'd0 && byte_d == 8'hFF) begin
              stg_commit <= 1'b1;
              st         <= S_SKIP;
            end else if (rcnt == CNT_W'(NUM_CH)) begin
              st <= S_SKIP;
            end else begin
              case (bcnt)
                3'd0: begin
                  rec.in_y  <= byte_d[7];
                  rec.out_y <= byte_d[6];
                  rec.alloc <= byte_d[4];
                end
                3'd1: begin
                  rec.dec  <= byte_d[6];
                  rec.rate <= byte_d[2:1];
                end
                3'd3: rec.in_b  <= byte_d;
                3'd4: rec.in_e  <= byte_d;
                3'd5: rec.out_b <= byte_d;
                3'd6: rec.out_e <= byte_d;
                default: ;
              endcase
              if (bcnt == 3'd6) begin
                rec_wr  <= 1'b1;
                rec_idx <= rcnt[CH_W-1:0];
                rcnt    <= rcnt + CNT_W'(1);
                bcnt    <= '0;
              end else begin
                bcnt <= bcnt + 3'd1;
              end
            end
          end
          S_CSTART: begin
            ptr <= {1'b0, byte_d};
            st  <= S_CHI;
          end
          S_CHI: begin
            hi_rst <= byte_d[4];
            hi_byp <= byte_d[2];
            hi_law <= byte_d[0];
            st     <= S_CLO;
          end
          S_CLO: begin
            if (ptr < 9'(NUM_CH)) begin
              ctl_wr  <= 1'b1;
              ctl_ch  <= ptr[CH_W-1:0];
              ctl_val <= '{rst: hi_rst, byp: hi_byp, law_a: hi_law, idle: byte_d[0]};
            end
            if (!ptr[8]) ptr <= ptr + 9'd1;
            st <= S_CHI;
          end
          S_PLL2: begin
            n_q  <= byte_d[7:1];
            m5_q <= byte_d[0];
            st   <= S_PLL3;
          end
          S_PLL3: begin
            pll_wr  <= 1'b1;
            pll_val <= '{fdiv: f_q, n: n_q, m: {m5_q, byte_d[7:3]}, p: byte_d[2:0]};
            st      <= S_SKIP;
          end
          S_SKIP: ;
          default: st <= S_SKIP;
        endcase
      end
    end
  end

  AST_PWR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_up && pwr_dn)); // R4
  AST_PWR_UP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> !pwr_up); // R4
  AST_PWR_DN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !pwr_dn); // R4
  AST_CTL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> (32'(ctl_ch) < NUM_CH)); // R9
  AST_REC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr |-> (32'(rec_idx) < NUM_CH)); // R7

endmodule

// File: rtl/tw_cfg_store.sv
module tw_cfg_store
  import tw_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stg_load,
  input  logic                    stg_commit,
  input  logic                    rec_wr,
  input  logic [CH_W-1:0]         rec_idx,
  input  setup_t                  rec,
  input  logic                    ctl_wr,
  input  logic [CH_W-1:0]         ctl_ch,
  input  ctl_t                    ctl_val,
  input  logic                    pll_wr,
  input  pll_t                    pll_val,
  output setup_t [NUM_CH-1:0]     live,
  output ctl_t   [NUM_CH-1:0]     ctl,
  output pll_t                    pll
);

  setup_t [NUM_CH-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        live[c]   <= setup_default(c, NUM_CH);
        shadow[c] <= setup_default(c, NUM_CH);
        ctl[c]    <= CTL_RST;
      end
      pll <= PLL_RST;
    end else begin
      if (stg_load) shadow <= live;
      else if (rec_wr) shadow[rec_idx] <= rec;
      if (stg_commit) live <= shadow;
      if (ctl_wr) ctl[ctl_ch] <= ctl_val;
      if (pll_wr) pll <= pll_val;
    end
  end

  AST_SETUP_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_commit |=> $stable(live)); // R6
  AST_CTL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl)); // R9
  AST_PLL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_wr |=> $stable(pll)); // R10

endmodule

// File: rtl/tw_cfg_decoder.sv
module tw_cfg_decoder
  import tw_cfg_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            chip_id,
  input  logic                  ser_clk,
  input  logic                  ser_csn,
  input  logic                  ser_dat,
  output logic [NUM_CH-1:0]     ch_in_y,
  output logic [NUM_CH-1:0]     ch_out_y,
  output logic [NUM_CH-1:0]     ch_alloc,
  output logic [NUM_CH-1:0]     ch_decode,
  output logic [2*NUM_CH-1:0]   ch_rate,
  output logic [8*NUM_CH-1:0]   ch_in_begin,
  output logic [8*NUM_CH-1:0]   ch_in_end,
  output logic [8*NUM_CH-1:0]   ch_out_begin,
  output logic [8*NUM_CH-1:0]   ch_out_end,
  output logic [NUM_CH-1:0]     ch_reset,
  output logic [NUM_CH-1:0]     ch_bypass,
  output logic [NUM_CH-1:0]     ch_law_a,
  output logic [NUM_CH-1:0]     ch_idle,
  output logic [3:0]            clk_div,
  output logic [6:0]            pll_n,
  output logic [5:0]            pll_m,
  output logic [2:0]            pll_p,
  output logic                  pwr_up,
  output logic                  pwr_dn
);

  logic                byte_vld, seq_start, seq_end;
  logic [7:0]          byte_d;
  logic                stg_load, stg_commit, rec_wr, ctl_wr, pll_wr;
  logic [CH_W-1:0]     rec_idx, ctl_ch;
  setup_t              rec;
  ctl_t                ctl_val;
  pll_t                pll_val, pll;
  setup_t [NUM_CH-1:0] live;
  ctl_t   [NUM_CH-1:0] ctl;

  tw_bit_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_dat(ser_dat),
    .byte_vld(byte_vld), .byte_d(byte_d), .seq_start(seq_start), .seq_end(seq_end)
  );

  tw_cmd_parser #(.NUM_CH(NUM_CH)) u_parse (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id),
    .byte_vld(byte_vld), .byte_d(byte_d), .seq_start(seq_start), .seq_end(seq_end),
    .pwr_up(pwr_up), .pwr_dn(pwr_dn), .stg_load(stg_load), .stg_commit(stg_commit),
    .rec_wr(rec_wr), .rec_idx(rec_idx), .rec(rec),
    .ctl_wr(ctl_wr), .ctl_ch(ctl_ch), .ctl_val(ctl_val),
    .pll_wr(pll_wr), .pll_val(pll_val)
  );

  tw_cfg_store #(.NUM_CH(NUM_CH)) u_store (
    .clk(clk), .rst_n(rst_n), .stg_load(stg_load), .stg_commit(stg_commit),
    .rec_wr(rec_wr), .rec_idx(rec_idx), .rec(rec),
    .ctl_wr(ctl_wr), .ctl_ch(ctl_ch), .ctl_val(ctl_val),
    .pll_wr(pll_wr), .pll_val(pll_val),
    .live(live), .ctl(ctl), .pll(pll)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
      assign ch_in_y[c]              = live[c].in_y;
      assign ch_out_y[c]             = live[c].out_y;
      assign ch_alloc[c]             = live[c].alloc;
      assign ch_decode[c]            = live[c].dec;
      assign ch_rate[2*c +: 2]       = live[c].rate;
      assign ch_in_begin[8*c +: 8]   = live[c].in_b;
      assign ch_in_end[8*c +: 8]     = live[c].in_e;
      assign ch_out_begin[8*c +: 8]  = live[c].out_b;
      assign ch_out_end[8*c +: 8]    = live[c].out_e;
      assign ch_reset[c]             = ctl[c].rst;
      assign ch_bypass[c]            = ctl[c].byp;
      assign ch_law_a[c]             = ctl[c].law_a;
      assign ch_idle[c]              = ctl[c].idle;
    end
  endgenerate

  assign clk_div = pll.fdiv;
  assign pll_n   = pll.n;
  assign pll_m   = pll.m;
  assign pll_p   = pll.p;

endmodule

// File: tb/tb_tw_cfg_decoder.sv
module tb_tw_cfg_decoder;

  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] chip_id = 2'b10;
  logic ser_clk = 1'b0;
  logic ser_csn = 1'b1;
  logic ser_dat = 1'b0;

  logic [NCH-1:0]   ch_in_y, ch_out_y, ch_alloc, ch_decode;
  logic [2*NCH-1:0] ch_rate;
  logic [8*NCH-1:0] ch_in_begin, ch_in_end, ch_out_begin, ch_out_end;
  logic [NCH-1:0]   ch_reset, ch_bypass, ch_law_a, ch_idle;
  logic [3:0] clk_div;
  logic [6:0] pll_n;
  logic [5:0] pll_m;
  logic [2:0] pll_p;
  logic pwr_up, pwr_dn;

  always #2 clk = ~clk;

  tw_cfg_decoder #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id),
    .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_dat(ser_dat),
    .ch_in_y(ch_in_y), .ch_out_y(ch_out_y), .ch_alloc(ch_alloc), .ch_decode(ch_decode),
    .ch_rate(ch_rate), .ch_in_begin(ch_in_begin), .ch_in_end(ch_in_end),
    .ch_out_begin(ch_out_begin), .ch_out_end(ch_out_end),
    .ch_reset(ch_reset), .ch_bypass(ch_bypass), .ch_law_a(ch_law_a), .ch_idle(ch_idle),
    .clk_div(clk_div), .pll_n(pll_n), .pll_m(pll_m), .pll_p(pll_p),
    .pwr_up(pwr_up), .pwr_dn(pwr_dn)
  );

  int checks = 0;
  int errors = 0;
  int up_cnt = 0, dn_cnt = 0, exp_up = 0, exp_dn = 0;

  logic [37:0] m_set [NCH];
  logic [3:0]  m_ctl [NCH];
  logic [19:0] m_pll;

  logic [7:0] sb [0:79];
  int nb;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pwr_up) up_cnt++;
      if (pwr_dn) dn_cnt++;
    end
  end

  // R1 encodings: {in_y,out_y,alloc,dec,rate,in_b,in_e,out_b,out_e}
  function automatic logic [37:0] def_setup(int ch);
    int j;
    if (ch < NCH/2)
      return {1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 8'(16*ch), 8'(16*ch+3), 8'(16*ch), 8'(16*ch+7)};
    j = ch - NCH/2;
    return {1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 8'(16*j), 8'(16*j+7), 8'(16*j), 8'(16*j+3)};
  endfunction

  function automatic logic [37:0] act_setup(int ch);
    return {ch_in_y[ch], ch_out_y[ch], ch_alloc[ch], ch_decode[ch], ch_rate[2*ch +: 2],
            ch_in_begin[8*ch +: 8], ch_in_end[8*ch +: 8], ch_out_begin[8*ch +: 8], ch_out_end[8*ch +: 8]};
  endfunction

  function automatic logic [3:0] act_ctl(int ch);
    return {ch_reset[ch], ch_bypass[ch], ch_law_a[ch], ch_idle[ch]};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_set[c] = def_setup(c);
      m_ctl[c] = 4'b1000;
    end
    m_pll = {4'd7, 7'd6, 6'd1, 3'd3};
  endtask

  // Apply the requirements to the first n complete bytes of sb.
  task automatic model_seq(input int n);
    logic [7:0]  h;
    logic [37:0] tmp [NCH];
    int k, r, ptr;
    bit commit;
    if (n == 0) return;
    h = sb[0];
    if (h[1:0] != chip_id) return;                     // R3
    if (h[7]) begin                                    // R10
      if (n >= 3) m_pll = {h[6:3], sb[1][7:1], sb[1][0], sb[2][7:3], sb[2][2:0]};
    end else if (h[7:2] == 6'b001100) begin            // R8
      if (n < 2) return;
      ptr = int'(sb[1]);
      k = 2;
      while (k + 1 < n) begin
        if (ptr < NCH) m_ctl[ptr] = {sb[k][4], sb[k][2], sb[k][0], sb[k+1][0]};
        ptr++;
        k += 2;
      end
    end else if (h[7:2] == 6'b000100) exp_up++;       // R4
    else if (h[7:2] == 6'b000010) exp_dn++;
    else if (h[7:2] == 6'b000000) begin                // R5
      for (int c = 0; c < NCH; c++) tmp[c] = m_set[c];
      k = 1; r = 0; commit = 0;
      while (k < n) begin
        if (sb[k] == 8'hFF) begin commit = 1; break; end
        if (r == NCH) break;                           // R7
        if (k + 7 > n) break;                          // R6
        tmp[r] = {sb[k][7], sb[k][6], sb[k][4], sb[k+1][6], sb[k+1][2:1],
                  sb[k+3], sb[k+4], sb[k+5], sb[k+6]};
        r++;
        k += 7;
      end
      if (commit) for (int c = 0; c < NCH; c++) m_set[c] = tmp[c];
    end
  endtask

  task automatic send_bit(input logic v);
    ser_dat = v;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_seq(input int n, input int extra);
    @(negedge clk);
    ser_csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) send_bit(sb[i][b]);
    for (int b = 0; b < extra; b++) send_bit(sb[n][b]);
    repeat (8) @(negedge clk);
    ser_csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic run(input int n, input int extra);
    send_seq(n, extra);
    model_seq(n);
  endtask

  task automatic put(input logic [7:0] v);
    sb[nb] = v;
    nb++;
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (act_setup(c) !== m_set[c]) begin
        errors++;
        $display("FAIL %s setup ch%0d actual %h expected %h", tag, c, act_setup(c), m_set[c]);
      end
      checks++;
      if (act_ctl(c) !== m_ctl[c]) begin
        errors++;
        $display("FAIL %s control ch%0d actual %b expected %b", tag, c, act_ctl(c), m_ctl[c]);
      end
    end
    checks++;
    if ({clk_div, pll_n, pll_m, pll_p} !== m_pll) begin
      errors++;
      $display("FAIL %s clock fields actual %h expected %h", tag, {clk_div, pll_n, pll_m, pll_p}, m_pll);
    end
    checks++;
    if (up_cnt != exp_up || dn_cnt != exp_dn) begin
      errors++;
      $display("FAIL %s strobes actual up=%0d dn=%0d expected up=%0d dn=%0d", tag, up_cnt, dn_cnt, exp_up, exp_dn);
    end
  endtask

  task automatic add_record(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] sa,
                            input logic [7:0] sb2, input logic [7:0] sc, input logic [7:0] sd);
    put(b0); put(b1); put(8'h00); put(sa); put(sb2); put(sc); put(sd);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R4: power-up, trailing power-down byte ignored
    nb = 0; put({6'b000100, chip_id}); put({6'b000010, chip_id});
    run(nb, 0); check_all("R4");
    nb = 0; put({6'b000010, chip_id});
    run(nb, 0); check_all("R4");

    // R3: wrong ID on power-up and on a full setup
    nb = 0; put({6'b000100, ~chip_id});
    run(nb, 0); check_all("R3");
    nb = 0; put({6'b000000, ~chip_id});
    add_record(8'h10, 8'h1E, 8'h40, 8'h47, 8'h40, 8'h43); put(8'hFF);
    run(nb, 0); check_all("R3");

    // R2: edges with select high ignored; partial byte dropped
    repeat (3) begin
      ser_dat = 1'b1; repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    nb = 0; put({6'b000100, chip_id});
    run(0, 5); check_all("R2");
    run(1, 0); check_all("R2");

    // R5: two records and footer
    nb = 0; put({6'b000000, chip_id});
    add_record(8'h10, 8'h44, 8'h80, 8'h83, 8'h90, 8'h97);
    add_record(8'hD0, 8'h02, 8'hA0, 8'hA7, 8'hB0, 8'hB3);
    put(8'hFF);
    run(nb, 0); check_all("R5");

    // R6: two complete records, third cut short, no footer
    nb = 0; put({6'b000000, chip_id});
    add_record(8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04);
    add_record(8'hC0, 8'h46, 8'h11, 8'h12, 8'h13, 8'h14);
    add_record(8'h40, 8'h40, 8'h21, 8'h22, 8'h23, 8'h24);
    run(nb - 3, 4); check_all("R6");

    // R7: nine records then footer
    nb = 0; put({6'b000000, chip_id});
    for (int r = 0; r < 9; r++) add_record(8'h80, 8'h06, 8'(r), 8'(r+1), 8'(r+2), 8'(r+3));
    put(8'hFF);
    run(nb, 0); check_all("R7");

    // R8/R9: start at 6, three pairs; pair for channel 8 ignored
    nb = 0; put({6'b001100, chip_id}); put(8'd6);
    put(8'h05); put(8'h01); put(8'h14); put(8'h00); put(8'h15); put(8'h01);
    run(nb, 0); check_all("R8");

    // R9: one full pair then a lone first byte
    nb = 0; put({6'b001100, chip_id}); put(8'd2);
    put(8'h01); put(8'h01); put(8'h04);
    run(nb, 0); check_all("R9");

    // R10: full clock command, then a two-byte one
    nb = 0; put({1'b1, 4'hB, 1'b0, chip_id}); put(8'hA5); put(8'h5C);
    run(nb, 0); check_all("R10");
    nb = 0; put({1'b1, 4'h3, 1'b0, chip_id}); put(8'h11);
    run(nb, 0); check_all("R10");

    // R11: unknown header followed by data
    nb = 0; put({6'b000001, chip_id}); put(8'h00); put(8'hFF); put(8'h10);
    run(nb, 0); check_all("R11");

    // Random mix
    for (int it = 0; it < 24; it++) begin
      int kind, full, n, ext;
      logic [1:0] id;
      id = ($urandom % 5 == 0) ? ~chip_id : chip_id;
      kind = $urandom % 4;
      nb = 0;
      if (kind == 0) begin
        int recs;
        recs = $urandom % 10;
        put({6'b000000, id});
        for (int r = 0; r < recs; r++) begin
          logic [7:0] b0;
          b0 = 8'($urandom);
          if (b0 == 8'hFF) b0 = 8'hFE;
          add_record(b0, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end
        put(8'hFF);
      end else if (kind == 1) begin
        int pairs;
        pairs = $urandom % 5;
        put({6'b001100, id}); put(8'($urandom % 10));
        for (int p = 0; p < pairs; p++) begin put(8'($urandom)); put(8'($urandom)); end
      end else if (kind == 2) begin
        put({1'b1, 4'($urandom), 1'b0, id}); put(8'($urandom)); put(8'($urandom));
      end else begin
        put({5'b00010 >> ($urandom % 2), 1'b0, id});
      end
      full = nb;
      n = full; ext = 0;
      if ($urandom % 4 == 0) begin
        n = $urandom % full;
        ext = $urandom % 8;
      end
      run(n, ext);
      check_all(kind == 0 ? "R5" : kind == 1 ? "R8" : kind == 2 ? "R10" : "R4");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule